// File: doc/BRIEF.md
# Hybrid Real-Time Thread Issue Scheduler

This block decides, on every clock cycle, which hardware thread of a multithreaded core may issue its next instruction. Each thread keeps its own context elsewhere, so the chosen thread issues in the same cycle it is picked. Switching between threads therefore costs nothing, and two neighbouring issue slots may belong to different threads.

Every thread is either hard-real-time or non-real-time, set by one configuration bit per thread. A programmable slot table fixes the order in which hard-real-time threads own issue slots. A pointer walks the table one entry per cycle and wraps at a programmable last index. A slot is free when its owner is not ready, when its entry is not valid, or when the entry names a non-real-time thread. A free slot goes to the ready non-real-time threads in round-robin order.

A thread stops being ready when software asks it to sleep. It becomes ready again when one of the event lines that its mask enables fires. The result is a plain valid flag with a thread ID. The downstream pipeline always takes it, so there is no back-pressure and no ready input. A cycle with the valid flag low is an idle bubble.

Top module: `thread_sched`

## Requirements
- R1: After reset the following state holds. Every table entry is invalid. The table pointer is at entry 0. The round-robin pointer is at thread 0. Every thread is ready.
- R2: The table pointer advances by one entry every cycle, including idle cycles. When the pointer is at or above `slot_last`, it returns to entry 0 on the next cycle.
- R3: The current entry may be valid, name a thread whose `rt_mask` bit is 1, and that thread may be ready. In that case the same cycle shows `issue_valid`=1, `issue_hrt`=1 and `issue_tid` equal to the entry's thread.
- R4: A free slot is granted to the first ready thread with `rt_mask` bit 0. The search starts at the round-robin pointer and goes upward, wrapping from thread 7 to thread 0. The grant shows `issue_hrt`=0. A hard-real-time thread never receives a free slot.
- R5: After a non-real-time grant to thread t, the round-robin pointer becomes t+1, modulo the thread count. After a hard-real-time grant or an idle cycle, the pointer is unchanged.
- R6: An entry with its valid bit 0 is a free slot. So is an entry that names a thread whose `rt_mask` bit is 0.
- R7: If a slot is free and no non-real-time thread is ready, then `issue_valid`=0, `issue_hrt`=0 and `issue_tid`=0.
- R8: A `sleep_req` bit clears that thread's ready bit at the next edge. Event line e wakes thread t at the next edge when `evt_in[e]` and `wake_mask[t*NUM_EVENTS+e]` are both 1. A wake wins over a sleep in the same cycle. The woken thread may issue in the cycle right after the event.
- R9: A table write takes effect at the clock edge. A write to the entry read in the same cycle does not change that cycle's choice and is used on the next pass through the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rt_mask | input | NUM_THREADS | 1 = thread is hard-real-time |
| slot_last | input | PTR_W | Last table index before the pointer wraps |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | PTR_W | Entry to write |
| tbl_wr_tid | input | TID_W | Thread ID stored in the entry |
| tbl_wr_valid | input | 1 | Valid bit stored in the entry |
| sleep_req | input | NUM_THREADS | Per-thread request to clear ready |
| evt_in | input | NUM_EVENTS | Wake event lines (interrupts, pin conditions) |
| wake_mask | input | NUM_THREADS*NUM_EVENTS | Per-thread event enables, thread t in bits t*NUM_EVENTS upward |
| issue_valid | output | 1 | A thread issues this cycle |
| issue_tid | output | TID_W | Issuing thread |
| issue_hrt | output | 1 | Grant came from the thread's own real-time slot |

## Verification
The main function is tried with four slot patterns. In the first, all threads are non-real-time over an empty table, which shows the round-robin rotation alone. In the second, the table mixes real-time owners, an invalid entry and an entry naming a non-real-time thread, which separates owned slots from reclaimed ones. In the third, a real-time owner is asleep: its slot must pass to non-real-time threads while other real-time threads gain nothing. In the fourth, every non-real-time thread is asleep, which separates a reclaimed slot from an idle bubble. Further runs shrink the table length below the current pointer, wake threads with an event and a sleep in the same cycle, and rewrite the entry under the pointer. A cycle-level reference model in the bench predicts every output.

// File: rtl/thread_sched_pkg.sv
package thread_sched_pkg;
  typedef enum logic [1:0] {
    GRANT_NONE = 2'd0,
    GRANT_HRT  = 2'd1,
    GRANT_NRT  = 2'd2
  } grant_kind_e;
endpackage

// File: rtl/thread_sched_slot_table.sv
module thread_sched_slot_table #(
  parameter int DEPTH = 64,
  parameter int TID_W = 3,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] slot_last,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [TID_W-1:0] wr_tid,
  input  logic             wr_valid,
  output logic             cur_valid,
  output logic [TID_W-1:0] cur_tid
);
  logic [PTR_W-1:0] ptr_q;
  logic [DEPTH-1:0] vld_q;
  logic [TID_W-1:0] tid_q [DEPTH];

  // Combinational read of the entry under the pointer; writes land at the edge.
  assign cur_valid = vld_q[ptr_q];
  assign cur_tid   = tid_q[ptr_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      vld_q <= '0;
    end else begin
      ptr_q <= (ptr_q >= slot_last) ? '0 : ptr_q + PTR_W'(1);
      if (wr_en) vld_q[wr_addr] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tid_q[wr_addr] <= wr_tid;
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q >= slot_last) |=> (ptr_q == '0)); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q < slot_last) |=> (ptr_q == $past(ptr_q) + PTR_W'(1))); // R2
endmodule

// File: rtl/thread_sched_ready.sv
module thread_sched_ready #(
  parameter int NUM_THREADS = 8,
  parameter int NUM_EVENTS  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_THREADS-1:0]          sleep_req,
  input  logic [NUM_EVENTS-1:0]           evt_in,
  input  logic [NUM_THREADS*NUM_EVENTS-1:0] wake_mask,
  output logic [NUM_THREADS-1:0]          ready
);
  logic [NUM_THREADS-1:0] wake;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_wake
    assign wake[t] = |(evt_in & wake_mask[t*NUM_EVENTS +: NUM_EVENTS]);

    AST_WAKE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      wake[t] |=> ready[t]); // R8
    AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_req[t] && !wake[t]) |=> !ready[t]); // R8
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ready <= '1;
    else        ready <= (ready & ~sleep_req) | wake;
  end
endmodule

// File: rtl/thread_sched_rr.sv
module thread_sched_rr #(
  parameter int NUM_THREADS = 8,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] req,
  input  logic                   advance,
  output logic                   found,
  output logic [TID_W-1:0]       grant
);
  logic [TID_W-1:0] rr_q;
  logic [TID_W-1:0] cand;
  logic [TID_W-1:0] next_ptr;

  always_comb begin
    found = 1'b0;
    grant = '0;
    cand  = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      cand = TID_W'((int'(rr_q) + i) % NUM_THREADS);
      if (!found && req[cand]) begin
        found = 1'b1;
        grant = cand;
      end
    end
  end

  assign next_ptr = (int'(grant) == NUM_THREADS - 1) ? '0 : grant + TID_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)       rr_q <= '0;
    else if (advance) rr_q <= next_ptr;
  end

  AST_RR_FOUND_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> req[grant]); // R4
  AST_RR_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (int'(rr_q) == (int'($past(grant)) + 1) % NUM_THREADS)); // R5
  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(rr_q)); // R5
endmodule

// File: rtl/thread_sched.sv
module thread_sched
  import thread_sched_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int TABLE_DEPTH = 64,
  parameter int NUM_EVENTS  = 4,
  localparam int TID_W = $clog2(NUM_THREADS),
  localparam int PTR_W = $clog2(TABLE_DEPTH)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_THREADS-1:0]            rt_mask,
  input  logic [PTR_W-1:0]                  slot_last,
  input  logic                              tbl_wr_en,
  input  logic [PTR_W-1:0]                  tbl_wr_addr,
  input  logic [TID_W-1:0]                  tbl_wr_tid,
  input  logic                              tbl_wr_valid,
  input  logic [NUM_THREADS-1:0]            sleep_req,
  input  logic [NUM_EVENTS-1:0]             evt_in,
  input  logic [NUM_THREADS*NUM_EVENTS-1:0] wake_mask,
  output logic                              issue_valid,
  output logic [TID_W-1:0]                  issue_tid,
  output logic                              issue_hrt
);
  logic             cur_valid;
  logic [TID_W-1:0] cur_tid;
  logic [NUM_THREADS-1:0] ready;
  logic [NUM_THREADS-1:0] nrt_req;
  logic             rr_found;
  logic [TID_W-1:0] rr_grant;
  logic             hrt_hit;
  grant_kind_e      kind;

  thread_sched_slot_table #(.DEPTH(TABLE_DEPTH), .TID_W(TID_W)) u_table (
    .clk(clk), .rst_n(rst_n), .slot_last(slot_last),
    .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr), .wr_tid(tbl_wr_tid), .wr_valid(tbl_wr_valid),
    .cur_valid(cur_valid), .cur_tid(cur_tid)
  );

  thread_sched_ready #(.NUM_THREADS(NUM_THREADS), .NUM_EVENTS(NUM_EVENTS)) u_ready (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .evt_in(evt_in),
    .wake_mask(wake_mask), .ready(ready)
  );

  // Owned slot: valid entry, owner is real-time and ready.
  assign hrt_hit = cur_valid && rt_mask[cur_tid] && ready[cur_tid];
  assign nrt_req = ready & ~rt_mask;

  thread_sched_rr #(.NUM_THREADS(NUM_THREADS)) u_rr (
    .clk(clk), .rst_n(rst_n), .req(nrt_req),
    .advance(!hrt_hit && rr_found),
    .found(rr_found), .grant(rr_grant)
  );

  always_comb begin
    if (hrt_hit)       kind = GRANT_HRT;
    else if (rr_found) kind = GRANT_NRT;
    else               kind = GRANT_NONE;
  end

  always_comb begin
    unique case (kind)
      GRANT_HRT: begin issue_valid = 1'b1; issue_hrt = 1'b1; issue_tid = cur_tid;  end
      GRANT_NRT: begin issue_valid = 1'b1; issue_hrt = 1'b0; issue_tid = rr_grant; end
      default:   begin issue_valid = 1'b0; issue_hrt = 1'b0; issue_tid = '0;       end
    endcase
  end

  AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ready[issue_tid]); // R3
  AST_NRT_NOT_RT: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_hrt) |-> !rt_mask[issue_tid]); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> (!issue_hrt && issue_tid == '0)); // R7
endmodule

// File: tb/thread_sched_test.sv
`timescale 1ns/100ps
module thread_sched_test;
  localparam int NT = 8;
  localparam int NE = 4;
  localparam int DEPTH = 64;
  localparam int PW = 6;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0] rt_mask = '0;
  logic [PW-1:0] slot_last = PW'(DEPTH - 1);
  logic tbl_wr_en = 1'b0;
  logic [PW-1:0] tbl_wr_addr = '0;
  logic [TW-1:0] tbl_wr_tid = '0;
  logic tbl_wr_valid = 1'b0;
  logic [NT-1:0] sleep_req = '0;
  logic [NE-1:0] evt_in = '0;
  logic [NT*NE-1:0] wake_mask = '0;
  logic issue_valid;
  logic [TW-1:0] issue_tid;
  logic issue_hrt;

  always #2.5 clk = ~clk;

  thread_sched uut (
    .clk(clk), .rst_n(rst_n), .rt_mask(rt_mask), .slot_last(slot_last),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_tid(tbl_wr_tid),
    .tbl_wr_valid(tbl_wr_valid), .sleep_req(sleep_req), .evt_in(evt_in),
    .wake_mask(wake_mask), .issue_valid(issue_valid), .issue_tid(issue_tid),
    .issue_hrt(issue_hrt)
  );

  typedef struct {
    logic v;
    logic [TW-1:0] tid;
    logic hrt;
    string req;
  } exp_t;

  exp_t exp_q[$];
  event smp_ev;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Reference model state
  int m_ptr;
  int m_rr;
  logic [NT-1:0] m_ready;
  logic m_tv [DEPTH];
  logic [TW-1:0] m_tt [DEPTH];

  task automatic model_reset();
    m_ptr = 0; m_rr = 0; m_ready = '1;
    for (int i = 0; i < DEPTH; i++) begin m_tv[i] = 1'b0; m_tt[i] = '0; end
  endtask

  // Driver: inputs are already set at the falling edge.
  task automatic cyc(string req);
    exp_t e;
    logic [NT-1:0] wake;
    bit found;
    e.v = 1'b0; e.tid = '0; e.hrt = 1'b0; e.req = req;
    if (m_tv[m_ptr] && rt_mask[m_tt[m_ptr]] && m_ready[m_tt[m_ptr]]) begin
      e.v = 1'b1; e.tid = m_tt[m_ptr]; e.hrt = 1'b1;
    end else begin
      found = 0;
      for (int i = 0; i < NT; i++) begin
        int idx;
        idx = (m_rr + i) % NT;
        if (!found && m_ready[idx] && !rt_mask[idx]) begin
          found = 1; e.v = 1'b1; e.tid = TW'(idx);
        end
      end
    end
    exp_q.push_back(e);
    #1 -> smp_ev;
    // next-state of the model
    if (e.v && !e.hrt) m_rr = (int'(e.tid) + 1) % NT;
    for (int t = 0; t < NT; t++) wake[t] = |(evt_in & wake_mask[t*NE +: NE]);
    m_ready = (m_ready & ~sleep_req) | wake;
    if (tbl_wr_en) begin m_tv[tbl_wr_addr] = tbl_wr_valid; m_tt[tbl_wr_addr] = tbl_wr_tid; end
    m_ptr = (m_ptr >= int'(slot_last)) ? 0 : m_ptr + 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_entry(int addr, int tid, bit vld, string req);
    tbl_wr_en = 1'b1; tbl_wr_addr = PW'(addr); tbl_wr_tid = TW'(tid); tbl_wr_valid = vld;
    cyc(req);
    tbl_wr_en = 1'b0;
  endtask

  // Monitor: compares DUT outputs with queued expectations.
  initial begin
    forever begin
      exp_t e;
      @(smp_ev);
      e = exp_q.pop_front();
      checks++;
      if (issue_valid !== e.v || issue_tid !== e.tid || issue_hrt !== e.hrt) begin
        fails++;
        $display("FAIL %s: got valid=%b tid=%0d hrt=%b, expected valid=%b tid=%0d hrt=%b",
                 e.req, issue_valid, issue_tid, issue_hrt, e.v, e.tid, e.hrt);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got no completion, expected end of stimulus");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, then R5 rotation with no real-time threads
    cyc("R1");
    for (int i = 0; i < 5; i++) cyc("R5");

    // Program a four-entry table; writes must not alter the cycle they occur in
    rt_mask = 8'h60;
    slot_last = PW'(3);
    write_entry(0, 5, 1'b1, "R9");
    write_entry(1, 6, 1'b1, "R9");
    write_entry(2, 0, 1'b0, "R9");
    write_entry(3, 1, 1'b1, "R9");
    for (int i = 0; i < 8; i++) cyc("R3");
    for (int i = 0; i < 4; i++) cyc("R6");

    // Owner of slot 0 sleeps: its slot goes to non-real-time threads only
    sleep_req = 8'h20; cyc("R8"); sleep_req = '0;
    for (int i = 0; i < 6; i++) cyc("R4");

    // All non-real-time threads sleep: free slots become bubbles
    sleep_req = 8'h9F; cyc("R8"); sleep_req = '0;
    for (int i = 0; i < 6; i++) cyc("R7");

    // Shrink the table below the pointer
    slot_last = PW'(1);
    for (int i = 0; i < 6; i++) cyc("R2");
    slot_last = PW'(3);
    for (int i = 0; i < 4; i++) cyc("R2");

    // Wake thread 5 on line 0 while a sleep is requested in the same cycle
    wake_mask[5*NE + 0] = 1'b1;
    wake_mask[2*NE + 1] = 1'b1;
    evt_in = 4'b0001; sleep_req = 8'h20; cyc("R8");
    evt_in = '0; sleep_req = '0;
    for (int i = 0; i < 4; i++) cyc("R8");

    // Rewrite the entry under the pointer: old entry used now, new on next pass
    write_entry(m_ptr, 6, 1'b1, "R9");
    for (int i = 0; i < 6; i++) cyc("R9");

    // Wake thread 2 on line 1; rotation resumes among ready non-real-time threads
    evt_in = 4'b0010; cyc("R8"); evt_in = '0;
    for (int i = 0; i < 6; i++) cyc("R5");
    rt_mask = '0;
    evt_in = 4'b0001; wake_mask = '1; cyc("R8"); evt_in = '0;
    for (int i = 0; i < 6; i++) cyc("R4");

    #1;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule